// File: doc/BRIEF.md
# FP32 to bfloat16 converter

This block narrows a single-precision floating-point word to the 16-bit brain-float format: 1 sign bit, 8 exponent bits with the same bias as single precision, and 7 stored fraction bits, so the significand including the hidden one is 8 bits. The exponent field is passed through. The 24-bit significand is shortened to 8 bits. A mode pin chooses between dropping the low bits and rounding to nearest with ties going to the even code.

Each input word is sorted into one of five classes: `CLS_ZERO`, `CLS_SUB` (subnormal), `CLS_NORM`, `CLS_INF` and `CLS_NAN`. A `unique case` over the class picks the result. Subnormals are not supported, so subnormal inputs become a zero with the input's sign. A rounding carry can ripple into the exponent. If that carry reaches the all-ones exponent, the result is infinity and the overflow flag is set. NaNs leave as quiet NaNs and infinities pass through unchanged.

The result is registered. The only register transition is a load when `in_valid` is high. While `in_valid` is low, the output word and flags hold their value.

Top module: `f2b_convert`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_half`, `out_ovf` and `out_inexact` are all 0.
- R2: `out_valid` equals `in_valid` from the previous clock. When `in_valid` was low, `out_half`, `out_ovf` and `out_inexact` keep their previous values.
- R3: With `rnd_mode`=0 (truncate), a normal input gives `in_word[31:16]` and `out_ovf` is never set. For example, 0x7F7FFFFF gives 0x7F7F.
- R4: With `rnd_mode`=1 (nearest-even), the dropped field `in_word[15:0]` controls rounding. Above 0x8000 the kept upper half is incremented; below 0x8000 it is kept as is. At exactly 0x8000 it is incremented only when bit 16 is 1.
- R5: A rounding increment carries from the fraction into the exponent. For example, 0x3FFFFFFF in mode 1 gives 0x4000.
- R6: In mode 1, when the rounded exponent would be 0xFF, the result is the signed infinity (magnitude 0x7F80) with `out_ovf`=1 and `out_inexact`=1. For example, 0xFF7FFFFF gives 0xFF80.
- R7: An input with exponent 0 gives a signed zero (0x0000 or 0x8000) with `out_ovf`=0. `out_inexact` is 1 when the input fraction is nonzero and 0 for a true zero.
- R8: An infinite input (exponent 0xFF, fraction 0) gives 0x7F80 or 0xFF80, with both flags 0.
- R9: A NaN input (exponent 0xFF, fraction nonzero) gives `{sign, 8'hFF, 1'b1, in_word[21:16]}`, with both flags 0.
- R10: For normal inputs in either mode, `out_inexact` is 1 exactly when `in_word[15:0]` is nonzero.
- R11: Around 65536 the codes are adjacent with steps of 256 below and 512 above. Truncating 0x477F0000, 0x47800000 and 0x47810000 gives 0x477F, 0x4780 and 0x4781. Under nearest-even, the midpoint 0x47808000 goes to the even code 0x4780.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load the converted value on this edge |
| rnd_mode | input | 1 | 0 = truncate, 1 = round to nearest, ties to even |
| in_word | input | 32 | Single-precision input word |
| out_valid | output | 1 | Output holds a newly converted value |
| out_half | output | 16 | Brain-float result |
| out_ovf | output | 1 | Rounding produced infinity from a finite input |
| out_inexact | output | 1 | Discarded bits were nonzero |

## Verification
The rounding carry into the exponent and the overflow to infinity can happen on the same conversion. When the carry reaches exponent 0xFF, the result must become infinity and must not become a large finite code. This case is forced by applying the largest finite single-precision values of both signs in nearest-even mode, and then the same words in truncate mode. Each result is judged against an independent reference model. That model decides rounding by comparing the dropped half-word with the midpoint, which differs from how the RTL computes it. The model expects infinity with `out_ovf` and `out_inexact` both set in the same cycle under nearest-even, and 0x7F7F/0xFF7F with no overflow under truncation.

// File: rtl/f2b_pkg.sv
package f2b_pkg;
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } f2b_class_e;
endpackage

// File: rtl/f2b_classify.sv
module f2b_classify
    import f2b_pkg::*;
#(
    parameter int EXP_W    = 8,
    parameter int IN_MAN_W = 23
) (
    input  logic [EXP_W-1:0]    exp_i,
    input  logic [IN_MAN_W-1:0] man_i,
    output f2b_class_e          cls_o
);
    logic exp_ones, exp_zero, man_zero;

    always_comb begin
        exp_ones = &exp_i;
        exp_zero = ~|exp_i;
        man_zero = ~|man_i;
        if (exp_ones)
            cls_o = man_zero ? CLS_INF : CLS_NAN;
        else if (exp_zero)
            cls_o = man_zero ? CLS_ZERO : CLS_SUB;
        else
            cls_o = CLS_NORM;
    end
endmodule

// File: rtl/f2b_round.sv
module f2b_round #(
    parameter int EXP_W     = 8,
    parameter int IN_MAN_W  = 23,
    parameter int OUT_MAN_W = 7,
    localparam int MAG_W    = EXP_W + IN_MAN_W,
    localparam int OMAG_W   = EXP_W + OUT_MAN_W,
    localparam int DROP_W   = IN_MAN_W - OUT_MAN_W
) (
    input  logic [MAG_W-1:0]  mag_i,
    input  logic              rne_i,
    output logic [OMAG_W-1:0] mag_o,
    output logic              ovf_o,
    output logic              lost_o
);
    logic [MAG_W-1:0] bias;
    logic [MAG_W-1:0] sum;

    always_comb begin
        bias = '0;
        if (rne_i)
            bias = {{(MAG_W-DROP_W+1){1'b0}}, {(DROP_W-1){1'b1}}}
                 + {{(MAG_W-1){1'b0}}, mag_i[DROP_W]};
        sum    = mag_i + bias;
        mag_o  = sum[MAG_W-1:DROP_W];
        ovf_o  = rne_i & (&sum[MAG_W-1:IN_MAN_W]);
        lost_o = |mag_i[DROP_W-1:0];
    end
endmodule

// File: rtl/f2b_convert.sv
module f2b_convert
    import f2b_pkg::*;
#(
    parameter int EXP_W     = 8,
    parameter int IN_MAN_W  = 23,
    parameter int OUT_MAN_W = 7,
    localparam int IN_W     = 1 + EXP_W + IN_MAN_W,
    localparam int OUT_W    = 1 + EXP_W + OUT_MAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             rnd_mode,
    input  logic [IN_W-1:0]  in_word,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_half,
    output logic             out_ovf,
    output logic             out_inexact
);
    logic                 sgn;
    logic [EXP_W-1:0]     exp_f;
    logic [IN_MAN_W-1:0]  man_f;
    f2b_class_e           cls;
    logic [OUT_W-2:0]     rnd_mag;
    logic                 rnd_ovf, rnd_lost;
    logic [OUT_W-1:0]     nxt_half;
    logic                 nxt_ovf, nxt_inexact;

    assign sgn   = in_word[IN_W-1];
    assign exp_f = in_word[IN_W-2 -: EXP_W];
    assign man_f = in_word[IN_MAN_W-1:0];

    f2b_classify #(.EXP_W(EXP_W), .IN_MAN_W(IN_MAN_W)) u_cls (
        .exp_i (exp_f),
        .man_i (man_f),
        .cls_o (cls)
    );

    f2b_round #(.EXP_W(EXP_W), .IN_MAN_W(IN_MAN_W), .OUT_MAN_W(OUT_MAN_W)) u_rnd (
        .mag_i  (in_word[IN_W-2:0]),
        .rne_i  (rnd_mode),
        .mag_o  (rnd_mag),
        .ovf_o  (rnd_ovf),
        .lost_o (rnd_lost)
    );

    // next-value process
    always_comb begin
        nxt_half    = {sgn, {(OUT_W-1){1'b0}}};
        nxt_ovf     = 1'b0;
        nxt_inexact = 1'b0;
        unique case (cls)
            CLS_NAN:  nxt_half = {sgn, {EXP_W{1'b1}}, 1'b1,
                                  man_f[IN_MAN_W-2 -: OUT_MAN_W-1]};
            CLS_INF:  nxt_half = {sgn, {EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}};
            CLS_ZERO: nxt_half = {sgn, {(OUT_W-1){1'b0}}};
            CLS_SUB:  begin
                nxt_half    = {sgn, {(OUT_W-1){1'b0}}};
                nxt_inexact = 1'b1;
            end
            CLS_NORM: begin
                nxt_inexact = rnd_lost;
                if (rnd_ovf) begin
                    nxt_half    = {sgn, {EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}};
                    nxt_ovf     = 1'b1;
                    nxt_inexact = 1'b1;
                end else begin
                    nxt_half = {sgn, rnd_mag};
                end
            end
            default:  nxt_half = {sgn, {(OUT_W-1){1'b0}}};
        endcase
    end

    // register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_half    <= '0;
            out_ovf     <= 1'b0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_half    <= nxt_half;
                out_ovf     <= nxt_ovf;
                out_inexact <= nxt_inexact;
            end
        end
    end
endmodule

// File: rtl/f2b_convert_chk.sv
module f2b_convert_chk #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 16,
    parameter int EXP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             rnd_mode,
    input logic [IN_W-1:0]  in_word,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_half,
    input logic             out_ovf,
    input logic             out_inexact
);
    localparam int MAN_W = IN_W - 1 - EXP_W;
    localparam int OMAN_W = OUT_W - 1 - EXP_W;

    logic in_nan, in_expz;
    assign in_nan  = (&in_word[IN_W-2 -: EXP_W]) & (|in_word[MAN_W-1:0]);
    assign in_expz = ~|in_word[IN_W-2 -: EXP_W];

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_half == '0 && !out_ovf && !out_inexact));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_half) && $stable(out_ovf) && $stable(out_inexact)));

    assert_no_trunc_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rnd_mode) |=> !out_ovf);

    assert_ovf_is_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> (out_half[OUT_W-2:0] == {{EXP_W{1'b1}}, {OMAN_W{1'b0}}} && out_inexact));

    assert_sub_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_expz) |=> (out_half[OUT_W-2:0] == '0 && !out_ovf));

    assert_nan_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_nan) |=> (out_half[OUT_W-2 -: EXP_W+1] == {(EXP_W+1){1'b1}}
                                  && !out_ovf && !out_inexact));

    assert_sign_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_half[OUT_W-1] == $past(in_word[IN_W-1])));
endmodule

bind f2b_convert f2b_convert_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .EXP_W(EXP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .rnd_mode    (rnd_mode),
    .in_word     (in_word),
    .out_valid   (out_valid),
    .out_half    (out_half),
    .out_ovf     (out_ovf),
    .out_inexact (out_inexact)
);

// File: tb/tb_f2b_convert.sv
module tb_f2b_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        rnd_mode = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [15:0] out_half;
    logic        out_ovf, out_inexact;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // expected state (reference model)
    logic        e_valid = 1'b0;
    logic [15:0] e_half = '0;
    logic        e_ovf = 1'b0, e_inex = 1'b0;
    string       e_tag = "R1";
    string       tag_q[$];
    logic [31:0] rng = 32'h1234_5678;

    always #4ns clk = ~clk;

    f2b_convert dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rnd_mode(rnd_mode),
        .in_word(in_word), .out_valid(out_valid), .out_half(out_half),
        .out_ovf(out_ovf), .out_inexact(out_inexact)
    );

    function automatic logic [17:0] model(input logic [31:0] w, input logic m);
        logic s; int e, f, hi, lo, r; logic ov, ix; logic [15:0] h;
        s = w[31]; e = int'(w[30:23]); f = int'(w[22:0]);
        hi = int'(w[30:16]); lo = int'(w[15:0]);
        ov = 0; ix = 0;
        if (e == 255) begin
            h = (f != 0) ? {s, 8'hFF, 1'b1, w[21:16]} : {s, 15'h7F80};
        end else if (e == 0) begin
            h = {s, 15'h0}; ix = (f != 0);
        end else begin
            ix = (lo != 0);
            r = hi;
            if (m && (lo > 32768 || (lo == 32768 && (hi % 2) == 1))) r = hi + 1;
            if (r >= 32'h7F80) begin h = {s, 15'h7F80}; ov = 1; end
            else h = {s, r[14:0]};
        end
        return {ov, ix, h};
    endfunction

    task automatic check1(input string what, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", e_tag, what, act, exp_v);
        end
    endtask

    task automatic compare();
        check1("valid (R2)", {31'b0, out_valid}, {31'b0, e_valid});
        check1("half", {16'b0, out_half}, {16'b0, e_half});
        check1("ovf", {31'b0, out_ovf}, {31'b0, e_ovf});
        check1("inexact", {31'b0, out_inexact}, {31'b0, e_inex});
    endtask

    task automatic step(input logic v, input logic [31:0] w, input logic m, input string tag);
        logic [17:0] r;
        @(negedge clk);
        compare();
        in_valid = v; in_word = w; rnd_mode = m;
        e_valid = v;
        if (v) begin
            r = model(w, m);
            e_half = r[15:0]; e_inex = r[16]; e_ovf = r[17];
            e_tag = tag;
        end else begin
            e_tag = "R2";
        end
        tag_q.push_back(tag);
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        #(8ns * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        in_word = 32'hFFFF_FFFF; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        e_tag = "R1";
        compare();                         // R1 reset state
        in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R3 truncation
        step(1, 32'h3F80_0000, 0, "R3");
        step(1, 32'h7F7F_FFFF, 0, "R3");
        step(1, 32'hFF7F_FFFF, 0, "R3");
        step(1, 32'h4049_0FDB, 0, "R3");
        // R4 nearest-even
        step(1, 32'h3F80_8001, 1, "R4");
        step(1, 32'h3F80_7FFF, 1, "R4");
        step(1, 32'h3F80_8000, 1, "R4");
        step(1, 32'h3F81_8000, 1, "R4");
        // R5 carry into exponent
        step(1, 32'h3FFF_FFFF, 1, "R5");
        step(1, 32'hBF7F_C000, 1, "R5");
        // R6 overflow, same-cycle carry
        step(1, 32'h7F7F_FFFF, 1, "R6");
        step(1, 32'hFF7F_FFFF, 1, "R6");
        step(1, 32'h7F7F_8000, 1, "R6");
        step(1, 32'h7F7F_7FFF, 1, "R6");
        // R7 subnormal and zero
        step(1, 32'h0000_0001, 1, "R7");
        step(1, 32'h807F_FFFF, 1, "R7");
        step(1, 32'h0000_0000, 0, "R7");
        step(1, 32'h8000_0000, 1, "R7");
        // R8 infinity
        step(1, 32'h7F80_0000, 1, "R8");
        step(1, 32'hFF80_0000, 0, "R8");
        // R9 NaN
        step(1, 32'h7F80_0001, 1, "R9");
        step(1, 32'hFFC1_2345, 0, "R9");
        step(1, 32'h7FBF_FFFF, 1, "R9");
        // R10 inexact in both modes
        step(1, 32'h4000_0001, 0, "R10");
        step(1, 32'h4000_0000, 1, "R10");
        // R11 spacing near 65536
        step(1, 32'h477F_0000, 0, "R11");
        step(1, 32'h4780_0000, 0, "R11");
        step(1, 32'h4781_0000, 0, "R11");
        step(1, 32'h4780_8000, 1, "R11");
        step(1, 32'h4780_8001, 1, "R11");
        // R2 hold with changing idle inputs
        step(0, 32'h0000_0001, 0, "R2");
        step(0, 32'h7F80_0001, 1, "R2");
        step(1, 32'h3F80_0000, 1, "R2");
        // mixed patterns (R4, R10)
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w;
            rng = next_rng(rng);
            w = rng;
            case (rng[3:0])
                4'd0: w[30:23] = 8'hFE;
                4'd1: w[30:23] = 8'h00;
                4'd2: w[30:23] = 8'hFF;
                4'd3: w[15:0]  = 16'h8000;
                default: ;
            endcase
            step(rng[9:4] != 6'd0, w, rng[10], "R4");
        end
        step(0, 32'h0, 0, "R2");
        @(negedge clk);
        compare();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule